// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

The router collects the level-sensitive interrupt pins of the devices on a PCI bus and folds them onto four shared request lines. Each device's pins are rotated by its slot number, so that devices in different slots spread their first pin across different shared lines. Each shared line then has a routing byte. The byte picks which one of sixteen legacy interrupt-controller inputs the line drives, or it leaves the line unconnected.

Software programs the four routing bytes through a dword-wide write port with byte lanes and can read them back. The block keeps one pending bit for every (controller input, shared line) pair. It rebuilds this map from the current line levels and the newly written routing on every cycle. A line that is moved or switched off therefore drops out of its old output at once, and no output stays stuck high. Every controller input is the OR of its pending bits and is driven from a register.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads back as 0x80 and all sixteen `pic_irq` outputs are low.
- R2: Bit `d*4+p` of `dev_irq` is pin p (0 = first pin) of device d, which sits in slot d+1. That pin drives shared line (p + slot − 1) mod 4.
- R3: A shared line whose routing byte holds a value n from 0 to 15 drives `pic_irq[n]`. Both 0 and 15 are valid outputs.
- R4: A shared line whose routing byte is 16 or greater is ignored: no output rises for it, whatever its level.
- R5: Each output is the OR of all shared lines currently routed to it. It stays high while any one of them is asserted.
- R6: When a line that is asserted is rerouted, its old output falls and its new output rises on the same clock edge that takes the write.
- R7: The routing bytes sit at byte address 0x60. Line k uses byte lane k of the dword (bits 8k+7..8k). A write changes only the lanes whose `cfg_be` bit is set. A write to any other dword changes nothing. `cfg_rdata` returns the routing bytes whenever `cfg_addr` selects that dword, and zero otherwise.
- R8: `pic_irq` changes exactly one clock edge after a change of `dev_irq` or a routing write, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 16 | Device interrupt pin levels, bit d*4+p |
| cfg_wr | input | 1 | Write strobe for the routing dword |
| cfg_addr | input | 6 | Byte address bits 7..2 (dword select) |
| cfg_be | input | 4 | Byte-lane enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected dword |
| pic_irq | output | 16 | Legacy interrupt-controller inputs |

## Verification
The hardest case to reach is a reroute while the line is held asserted. The old output must fall and the new one must rise on one and the same edge, and a second line sharing the old output must keep it high. The stimulus holds a device pin high across a routing write. It also stacks two lines onto one output and releases them one at a time. A cycle-by-cycle scoreboard compares every output bit against the model on each edge, so a stale map bit or a latency of one extra cycle is visible.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int ROUTE_W      = 8;
    localparam int CFG_DATA_W   = 32;
    localparam int CFG_LANES    = CFG_DATA_W / ROUTE_W;
    localparam int DEF_LINES    = 4;
    localparam int DEF_OUTS     = 16;
    localparam int DEF_DEVS     = 4;
    localparam int DEF_ADDR_W   = 8;
    typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
    parameter int NUM_DEV    = pirq_pkg::DEF_DEVS,
    parameter int NUM_LINES  = pirq_pkg::DEF_LINES,
    parameter int FIRST_SLOT = 1
) (
    input  logic [NUM_DEV*NUM_LINES-1:0] dev_irq,
    output logic [NUM_LINES-1:0]         line_lvl
);
    localparam int PINS = NUM_LINES;

    // each device pin lands on a shared line rotated by its slot
    always_comb begin
        line_lvl = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int p = 0; p < PINS; p++) begin
                line_lvl[(p + d + FIRST_SLOT - 1) % NUM_LINES] =
                    line_lvl[(p + d + FIRST_SLOT - 1) % NUM_LINES] | dev_irq[d*PINS + p];
            end
        end
    end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int              NUM_LINES   = pirq_pkg::DEF_LINES,
    parameter int              ADDR_W      = pirq_pkg::DEF_ADDR_W,
    parameter int              BASE_ADDR   = 'h60,
    parameter pirq_pkg::route_t RESET_ROUTE = 8'h80
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cfg_wr,
    input  logic [ADDR_W-1:2]                          cfg_addr,
    input  logic [pirq_pkg::CFG_LANES-1:0]             cfg_be,
    input  logic [pirq_pkg::CFG_DATA_W-1:0]            cfg_wdata,
    output logic [pirq_pkg::CFG_DATA_W-1:0]            cfg_rdata,
    output pirq_pkg::route_t [NUM_LINES-1:0]           route_d,
    output pirq_pkg::route_t [NUM_LINES-1:0]           route_q
);
    import pirq_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);

    typedef struct packed {
        route_t [NUM_LINES-1:0] route;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit;

    assign hit = (cfg_addr == BASE_VEC[ADDR_W-1:2]);

    always_comb begin
        st_d = st_q;
        if (cfg_wr && hit) begin
            for (int k = 0; k < NUM_LINES; k++) begin
                if (cfg_be[k]) begin
                    st_d.route[k] = cfg_wdata[k*ROUTE_W +: ROUTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.route <= {NUM_LINES{RESET_ROUTE}};
        end else begin
            st_q <= st_d;
        end
    end

    assign route_d = st_d.route;
    assign route_q = st_q.route;

    for (genvar k = 0; k < CFG_LANES; k++) begin : g_lane
        if (k < NUM_LINES) begin : g_used
            assign cfg_rdata[k*ROUTE_W +: ROUTE_W] = hit ? st_q.route[k] : '0;
        end else begin : g_spare
            assign cfg_rdata[k*ROUTE_W +: ROUTE_W] = '0;
        end
    end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
    parameter int NUM_LINES = pirq_pkg::DEF_LINES,
    parameter int NUM_OUTS  = pirq_pkg::DEF_OUTS
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  pirq_pkg::route_t [NUM_LINES-1:0]      route_nxt,
    input  logic [NUM_LINES-1:0]                  line_lvl,
    output logic [NUM_OUTS*NUM_LINES-1:0]         map_q,
    output logic [NUM_OUTS-1:0]                   pic_irq
);
    import pirq_pkg::*;

    localparam int MAP_W = NUM_OUTS * NUM_LINES;

    typedef struct packed {
        logic [MAP_W-1:0]    map;
        logic [NUM_OUTS-1:0] irq;
    } lvl_t;

    lvl_t st_d, st_q;

    // rebuild the whole map every cycle from the routing about to take effect
    always_comb begin
        st_d = '0;
        for (int o = 0; o < NUM_OUTS; o++) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                st_d.map[o*NUM_LINES + l] = line_lvl[l] &&
                    (route_nxt[l] < route_t'(NUM_OUTS)) &&
                    (route_nxt[l] == route_t'(o));
            end
            st_d.irq[o] = |st_d.map[o*NUM_LINES +: NUM_LINES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_q   = st_q.map;
    assign pic_irq = st_q.irq;
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
    parameter int NUM_DEV    = pirq_pkg::DEF_DEVS,
    parameter int NUM_LINES  = pirq_pkg::DEF_LINES,
    parameter int NUM_OUTS   = pirq_pkg::DEF_OUTS,
    parameter int FIRST_SLOT = 1,
    parameter int ADDR_W     = pirq_pkg::DEF_ADDR_W,
    parameter int BASE_ADDR  = 'h60
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_DEV*NUM_LINES-1:0]        dev_irq,
    input  logic                                cfg_wr,
    input  logic [ADDR_W-1:2]                   cfg_addr,
    input  logic [pirq_pkg::CFG_LANES-1:0]      cfg_be,
    input  logic [pirq_pkg::CFG_DATA_W-1:0]     cfg_wdata,
    output logic [pirq_pkg::CFG_DATA_W-1:0]     cfg_rdata,
    output logic [NUM_OUTS-1:0]                 pic_irq
);
    import pirq_pkg::*;

    logic [NUM_LINES-1:0]          line_lvl;
    route_t [NUM_LINES-1:0]        route_d;
    route_t [NUM_LINES-1:0]        route_q;
    logic [NUM_OUTS*NUM_LINES-1:0] map_q;

    pirq_swizzle #(
        .NUM_DEV    (NUM_DEV),
        .NUM_LINES  (NUM_LINES),
        .FIRST_SLOT (FIRST_SLOT)
    ) i_swizzle (
        .dev_irq  (dev_irq),
        .line_lvl (line_lvl)
    );

    pirq_route_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .route_d   (route_d),
        .route_q   (route_q)
    );

    pirq_level_map #(
        .NUM_LINES (NUM_LINES),
        .NUM_OUTS  (NUM_OUTS)
    ) i_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .route_nxt (route_d),
        .line_lvl  (line_lvl),
        .map_q     (map_q),
        .pic_irq   (pic_irq)
    );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
    parameter int NUM_DEV    = pirq_pkg::DEF_DEVS,
    parameter int NUM_LINES  = pirq_pkg::DEF_LINES,
    parameter int NUM_OUTS   = pirq_pkg::DEF_OUTS,
    parameter int FIRST_SLOT = 1,
    parameter int ADDR_W     = pirq_pkg::DEF_ADDR_W,
    parameter int BASE_ADDR  = 'h60
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_DEV*NUM_LINES-1:0]        dev_irq,
    input logic                                cfg_wr,
    input logic [ADDR_W-1:2]                   cfg_addr,
    input logic [pirq_pkg::CFG_LANES-1:0]      cfg_be,
    input logic [pirq_pkg::CFG_DATA_W-1:0]     cfg_wdata,
    input logic [NUM_OUTS-1:0]                 pic_irq,
    input pirq_pkg::route_t [NUM_LINES-1:0]    route_q,
    input logic [NUM_OUTS*NUM_LINES-1:0]       map_q
);
    import pirq_pkg::*;

    localparam int                OUT_IDX_W = $clog2(NUM_OUTS);
    localparam logic [ADDR_W-1:0] BASE_VEC  = ADDR_W'(BASE_ADDR);

    logic                 wr_hit;
    logic                 all_off;
    logic [NUM_LINES-1:0] lvl;

    assign wr_hit = cfg_wr && (cfg_addr == BASE_VEC[ADDR_W-1:2]);

    always_comb begin
        all_off = 1'b1;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (route_q[l] < route_t'(NUM_OUTS)) all_off = 1'b0;
        end
        lvl = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int p = 0; p < NUM_LINES; p++) begin
                if (dev_irq[d*NUM_LINES + p]) lvl[(p + d + FIRST_SLOT - 1) % NUM_LINES] = 1'b1;
            end
        end
    end

    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && all_off) |=> (pic_irq == '0)); // R4

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [NUM_OUTS-1:0] col;
        always_comb begin
            for (int o = 0; o < NUM_OUTS; o++) col[o] = map_q[o*NUM_LINES + l];
        end

        AST_LINE_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col)); // R3

        AST_ROUTED_RISES: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_wr && lvl[l] && (route_q[l] < route_t'(NUM_OUTS)))
                |=> pic_irq[route_q[l][OUT_IDX_W-1:0]]); // R5

        AST_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && cfg_be[l]) |=> (route_q[l] == $past(cfg_wdata[l*ROUTE_W +: ROUTE_W]))); // R7

        AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_hit && cfg_be[l]) |=> $stable(route_q[l])); // R7
    end
endmodule

bind pirq_router pirq_router_chk #(
    .NUM_DEV    (NUM_DEV),
    .NUM_LINES  (NUM_LINES),
    .NUM_OUTS   (NUM_OUTS),
    .FIRST_SLOT (FIRST_SLOT),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR)
) i_pirq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .pic_irq   (pic_irq),
    .route_q   (route_q),
    .map_q     (map_q)
);

// File: tb/test_pirq_router.sv
module test_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dev_irq = '0;
    logic        cfg_wr = 1'b0;
    logic [7:2]  cfg_addr = 6'h18;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] pic_irq;

    localparam logic [7:2] RT_DW = 6'h18;   // byte address 0x60

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [15:0] irq;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [7:0] mr [4];

    always #2 clk = ~clk;

    pirq_router i_pirq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pic_irq   (pic_irq)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model built from the requirements: slot d+1, line (p+d) mod 4
    function automatic logic [15:0] model(input logic [15:0] dev);
        logic [3:0]  ln;
        logic [15:0] o;
        ln = '0;
        o  = '0;
        for (int d = 0; d < 4; d++)
            for (int p = 0; p < 4; p++)
                if (dev[d*4+p]) ln[(p+d)%4] = 1'b1;
        for (int l = 0; l < 4; l++)
            if (ln[l] && mr[l] < 8'd16) o[mr[l][3:0]] = 1'b1;
        return o;
    endfunction

    task automatic drive(input logic [15:0] dev, input logic wr, input logic [7:2] a,
                         input logic [3:0] be, input logic [31:0] d, input string tag);
        @(negedge clk);
        dev_irq   = dev;
        cfg_wr    = wr;
        cfg_addr  = a;
        cfg_be    = be;
        cfg_wdata = d;
        if (wr && a == RT_DW)
            for (int k = 0; k < 4; k++)
                if (be[k]) mr[k] = d[8*k +: 8];
        exp_q.push_back('{model(dev), tag});
    endtask

    task automatic hold(input logic [15:0] dev, input string tag);
        drive(dev, 1'b0, RT_DW, 4'h0, 32'h0, tag);
    endtask

    task automatic check_rd(input logic [7:2] a, input logic [31:0] exp, input string tag);
        drive(dev_irq, 1'b0, a, 4'h0, 32'h0, tag);
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    // monitor: one expected item per clock edge, sampled 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(pic_irq == e.irq, e.tag, {16'h0, pic_irq}, {16'h0, e.irq});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) mr[k] = 8'h80;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check(pic_irq == 16'h0, "R1", {16'h0, pic_irq}, 32'h0);
        check(cfg_rdata == 32'h80808080, "R1", cfg_rdata, 32'h80808080);

        // every pin high while all lines are disabled
        hold(16'hFFFF, "R4");
        hold(16'hFFFF, "R4");
        hold(16'h0000, "R4");

        // line 0 to output 5; device 0 pin 0 reaches line 0
        drive(16'h0, 1'b1, RT_DW, 4'b0001, 32'h05, "R7");
        check_rd(RT_DW, 32'h80808005, "R7");
        hold(16'h0001, "R3");
        hold(16'h0001, "R8");

        // two lines share output 5
        drive(16'h0001, 1'b1, RT_DW, 4'b0010, 32'h0500, "R5");
        hold(16'h0011, "R5");
        hold(16'h0010, "R5");
        hold(16'h0000, "R5");

        // distinct outputs per line, then every pin alone
        drive(16'h0, 1'b1, RT_DW, 4'b1111, 32'h04030201, "R7");
        check_rd(RT_DW, 32'h04030201, "R7");
        for (int i = 0; i < 16; i++) hold(16'(1 << i), "R2");
        hold(16'h0, "R2");
        hold(16'h0008, "R8");
        hold(16'h0000, "R8");

        // move an asserted line from output 1 to output 9
        hold(16'h0001, "R6");
        drive(16'h0001, 1'b1, RT_DW, 4'b0001, 32'h09, "R6");
        hold(16'h0001, "R6");

        // boundaries: 0 and 15 are outputs, 16 is not
        drive(16'h0001, 1'b1, RT_DW, 4'b0001, 32'h0F, "R3");
        hold(16'h0001, "R3");
        drive(16'h0001, 1'b1, RT_DW, 4'b0001, 32'h00, "R3");
        drive(16'h0001, 1'b1, RT_DW, 4'b0001, 32'h10, "R4");
        hold(16'h0001, "R4");
        hold(16'hFFFF, "R4");

        // other dword and partial lanes
        drive(16'hFFFF, 1'b1, 6'h19, 4'b1111, 32'h0, "R7");
        check_rd(RT_DW, 32'h04030210, "R7");
        check_rd(6'h19, 32'h0, "R7");
        drive(16'hFFFF, 1'b1, RT_DW, 4'b0100, 32'h0F0F0F0F, "R7");
        check_rd(RT_DW, 32'h040F0210, "R7");
        hold(16'h0000, "R5");

        while (exp_q.size() > 0) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule